// File: doc/BRIEF.md
# I2C Clock Divider and Filter Strobe Generator

This block sits beside an I2C master's bus engine. From the system clock it produces two periodic strobes. The first is a half-period tick that the engine uses to time the low and high phases of SCL. The second is a sample strobe that paces the engine's input glitch filter. The bus rate is set by two values. One is a 6-bit divider code. The other is an 8-bit filter rate.

The divider code is not a plain count. Its bits hold two scattered select fields, one for an additive factor A and one for a power-of-two factor B. The filter rate is also folded into the final ratio, so a slower filter lengthens the SCL period. The block works out the ratio at the moment the controller is enabled and holds it in a register. From then on the tick path is only a counter and a compare. A ready flag shows that the latched settings are in force.

Top module: `scl_div_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ready`, `half_tick` and `flt_strobe` are all low.
- R2: The divide ratio is B*(A + 2*floor(3*F/B)), where F is the effective filter rate. While running, `half_tick` pulses for one cycle once every max(floor(ratio/2),1) clocks. The first pulse comes in the last cycle of the first such interval after `ready` rises.
- R3: B equals 16 shifted left by `fdr_code[4:2]`, which gives 16, 32 and so on up to 2048.
- R4: The A select is {`fdr_code[5]`, `fdr_code[1:0]`}. Selects 0 through 7 map to A = 10, 12, 14, 16, 18, 20, 24 and 30.
- R5: A filter rate of 0 is treated as 1, both in the ratio and for the strobe period.
- R6: While running, `flt_strobe` pulses once every F clocks. With F = 1 it is high in every running cycle.
- R7: `fdr_code` and `flt_rate` are sampled only in the cycle where `enable` is first seen high. Changes made while enabled have no effect on either strobe.
- R8: `ready` rises on the clock edge that first sees `enable` high and falls on the edge that sees it low. Both strobes are low in any cycle where `enable` or `ready` is low.
- R9: Each new enable restarts both strobe phases from zero, whatever the phase was when the block was last disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; its rising edge latches the settings |
| fdr_code | input | 6 | Divider code holding the A and B selects |
| flt_rate | input | 8 | Filter sampling rate in system clocks (0 means 1) |
| half_tick | output | 1 | One-cycle pulse at each SCL half period |
| flt_strobe | output | 1 | One-cycle input filter sample pulse |
| ready | output | 1 | Latched settings are active |

## Verification
The bench targets the scattered select bits. It uses codes whose A select depends on bit 5, and the largest B select, where a design that mixed up the bit positions would tick at a clearly different rate. It drives a filter rate of zero, which a design without the substitution would either never strobe on or count through a full wrap. It also drives a filter rate large enough that the floor term changes the ratio, so a design that left that term out would tick early. Finally, it changes the settings while enabled and re-enables in mid-phase. A design that re-read the inputs or kept stale counter state would then move its tick positions away from those the model expects.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;
    localparam int FDR_W   = 6;
    localparam int FLT_W   = 8;
    localparam int RATIO_W = 16;
    localparam int BSEL_W  = 3;
    localparam int ASEL_W  = 3;
    localparam int B_BASE  = 16;

    typedef struct packed {
        logic [RATIO_W-1:0] half;
        logic [FLT_W-1:0]   flt;
    } div_cfg_t;

    function automatic logic [RATIO_W-1:0] a_value(input logic [ASEL_W-1:0] sel);
        logic [RATIO_W-1:0] v;
        case (sel)
            3'd0:    v = RATIO_W'(10);
            3'd1:    v = RATIO_W'(12);
            3'd2:    v = RATIO_W'(14);
            3'd3:    v = RATIO_W'(16);
            3'd4:    v = RATIO_W'(18);
            3'd5:    v = RATIO_W'(20);
            3'd6:    v = RATIO_W'(24);
            default: v = RATIO_W'(30);
        endcase
        return v;
    endfunction

    function automatic logic [RATIO_W-1:0] full_ratio(input logic [FDR_W-1:0] code,
                                                      input logic [FLT_W-1:0] rate_eff);
        logic [RATIO_W-1:0] b;
        logic [RATIO_W-1:0] a;
        logic [RATIO_W-1:0] q;
        b = RATIO_W'(B_BASE) << code[4:2];
        a = a_value({code[5], code[1:0]});
        q = (RATIO_W'(rate_eff) * RATIO_W'(3)) / b;
        return b * (a + (q << 1));
    endfunction
endpackage

// File: rtl/scl_div_decode.sv
`timescale 1ns/1ps
module scl_div_decode
    import scl_div_pkg::*;
(
    input  logic [FDR_W-1:0] code,
    input  logic [FLT_W-1:0] rate,
    output div_cfg_t         cfg
);
    logic [FLT_W-1:0]   rate_eff;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half_raw;

    always_comb begin
        rate_eff = (rate == '0) ? FLT_W'(1) : rate;
        ratio    = full_ratio(code, rate_eff);
        half_raw = ratio >> 1;
        cfg.half = (half_raw == '0) ? RATIO_W'(1) : half_raw;
        cfg.flt  = rate_eff;
    end
endmodule

// File: rtl/scl_div_ticker.sv
`timescale 1ns/1ps
module scl_div_ticker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == period - CNT_W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= at_end ? '0 : cnt + CNT_W'(1);
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < period));
endmodule

// File: rtl/scl_div_gen.sv
`timescale 1ns/1ps
module scl_div_gen
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [FDR_W-1:0] fdr_code,
    input  logic [FLT_W-1:0] flt_rate,
    output logic             half_tick,
    output logic             flt_strobe,
    output logic             ready
);
    div_cfg_t cfg_next;
    div_cfg_t cfg_q;
    logic     en_q;
    logic     ready_q;
    logic     rise;
    logic     run;
    logic     clear;

    scl_div_decode u_decode (
        .code (fdr_code),
        .rate (flt_rate),
        .cfg  (cfg_next)
    );

    assign rise  = enable && !en_q;
    assign run   = enable && ready_q;
    assign clear = !enable || rise;
    assign ready = ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            ready_q  <= 1'b0;
            cfg_q    <= '{half: RATIO_W'(1), flt: FLT_W'(1)};
        end else begin
            en_q <= enable;
            if (rise) begin
                cfg_q   <= cfg_next;
                ready_q <= 1'b1;
            end else if (!enable) begin
                ready_q <= 1'b0;
            end
        end
    end

    scl_div_ticker #(.CNT_W(RATIO_W)) u_half (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .run    (run),
        .period (cfg_q.half),
        .tick   (half_tick)
    );

    scl_div_ticker #(.CNT_W(FLT_W)) u_flt (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .run    (run),
        .period (cfg_q.flt),
        .tick   (flt_strobe)
    );

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !ready);
    // R8
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !en_q) |=> ready);
    // R8
    strobes_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (half_tick || flt_strobe) |-> (enable && ready));
    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> $stable(cfg_q));
    // R5
    flt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cfg_q.flt != '0));
endmodule

// File: tb/scl_div_gen_test.sv
`timescale 1ns/1ps
module scl_div_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [5:0] fdr_code = '0;
    logic [7:0] flt_rate = '0;
    logic       half_tick;
    logic       flt_strobe;
    logic       ready;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // model state
    bit m_ready = 0;
    bit m_en_prev = 0;
    int m_half = 1;
    int m_flt = 1;
    int m_ct = 0;
    int m_cf = 0;

    scl_div_gen uut (
        .clk(clk), .rst(rst), .enable(enable), .fdr_code(fdr_code),
        .flt_rate(flt_rate), .half_tick(half_tick), .flt_strobe(flt_strobe),
        .ready(ready)
    );

    always #2.5 clk = ~clk;

    function automatic int model_a(input int sel);
        int tbl[8] = '{10, 12, 14, 16, 18, 20, 24, 30};
        return tbl[sel];
    endfunction

    function automatic int model_half(input int code, input int rate);
        int f, a, b, r, h;
        f = (rate == 0) ? 1 : rate;                         // R5
        b = 16 * (2 ** ((code >> 2) & 7));                  // R3
        a = model_a((((code >> 5) & 1) * 4) + (code & 3));  // R4
        r = b * (a + 2 * ((3 * f) / b));                    // R2
        h = r / 2;
        return (h < 1) ? 1 : h;
    endfunction

    task automatic check(input string req, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit run, e_tick, e_str;
            run    = enable && m_ready && !rst;
            e_tick = run && (m_ct == m_half - 1);
            e_str  = run && (m_cf == m_flt - 1);
            check({cur_req, "/R8"}, ready, m_ready, "ready");
            check({cur_req, "/R2"}, half_tick, e_tick, "half_tick");
            check({cur_req, "/R6"}, flt_strobe, e_str, "flt_strobe");
            if (rst) begin
                m_ready = 0; m_en_prev = 0; m_ct = 0; m_cf = 0;
            end else begin
                if (enable && !m_en_prev) begin             // R7, R9
                    m_half = model_half(fdr_code, flt_rate);
                    m_flt = (flt_rate == 0) ? 1 : flt_rate;
                    m_ready = 1; m_ct = 0; m_cf = 0;
                end else if (!enable) begin
                    m_ready = 0; m_ct = 0; m_cf = 0;
                end else if (run) begin
                    m_ct = (m_ct + 1) % m_half;
                    m_cf = (m_cf + 1) % m_flt;
                end
                m_en_prev = enable;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_case(input string req, input logic [5:0] code,
                            input logic [7:0] rate, input int n);
        cur_req = req;
        fdr_code = code; flt_rate = rate; enable = 1'b1;
        step(n);
        enable = 1'b0;
        step(3);
    endtask

    task automatic report;
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        cur_req = "R1";
        step(3);
        @(negedge clk); #0.5;
        check("R1", ready, 1'b0, "ready in reset");
        check("R1", half_tick, 1'b0, "half_tick in reset");
        rst = 1'b0;
        step(1);
        check("R1", ready, 1'b0, "ready after reset");
        run_case("R2", 6'h00, 8'd1, 400);          // half 80
        run_case("R3", 6'h1C, 8'd1, 21000);        // B=2048, half 10240
        run_case("R4", 6'h23, 8'd3, 1200);         // A=30, half 240
        run_case("R4", 6'h25, 8'd16, 1500);        // A=20 B=32, half 352
        run_case("R6", 6'h02, 8'd200, 3000);       // floor term 37, half 704
        run_case("R5", 6'h00, 8'd0, 500);          // rate 0 acts as 1
        // R7: change settings while enabled
        cur_req = "R7";
        fdr_code = 6'h00; flt_rate = 8'd5; enable = 1'b1;
        step(100);
        fdr_code = 6'h1C; flt_rate = 8'd9;
        step(600);
        enable = 1'b0;
        step(3);
        // R9: disable mid-phase and re-enable
        cur_req = "R9";
        fdr_code = 6'h04; flt_rate = 8'd7; enable = 1'b1;
        step(250);
        enable = 1'b0;
        step(1);
        enable = 1'b1;
        step(700);
        enable = 1'b0;
        step(3);
        report();
    end
endmodule